// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and three interval-timer channel counters. The host writes a control word to a single control address to program one channel's access pattern, counting mode and BCD flag, to freeze a channel's count, or to issue a read-back command. That command can freeze the count and the status of several channels at once. The three other addresses are per-channel data ports. Through them the host loads 16-bit initial counts and reads back counts or status a byte at a time.

For each channel the block keeps its own write-byte sequence and read-byte sequence, a staging byte for two-byte loads, a count snapshot and a status snapshot. It hands each finished initial count to the channel counter with a one-cycle load strobe. It drives each counter's mode and BCD flag, and it samples each counter's live value and output level. The counters and any interrupt logic live outside this block.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel uses the low-then-high access pattern with both byte sequences at the first byte, mode 0, BCD 0, no snapshot pending, and `cnt_load` low.
- R2: A control word carries the channel in bits 7:6 (3 selects read-back), the access pattern in bits 5:4 (0 freeze count, 1 low byte only, 2 high byte only, 3 low then high), the mode in bits 3:1 and BCD in bit 0. A nonzero access value updates that channel's `cnt_mode` and `cnt_bcd` one cycle after the write. Nothing else changes them.
- R3: Programming a channel with a nonzero access value restarts its read and write sequences at the first byte and discards its pending count and status snapshots.
- R4: Data writes load `{8'h00, byte}` in low-only access and `{byte, 8'h00}` in high-only access. In low-then-high access the first byte is staged and the second loads `{second, first}`. `cnt_load` for that channel is high, with `cnt_init` valid, only in the cycle after the completing write.
- R5: With nothing pending, a data read returns the live low byte (low-only), the live high byte (high-only), or alternates low then high starting with low (low-then-high). The read sequence advances independently of the write sequence.
- R6: A freeze-count command captures the live count at the write. Later reads return the captured bytes following the channel's access pattern. The snapshot is released after its last byte, and live reads follow.
- R7: A request to freeze the count while an earlier count snapshot still has unread bytes has no effect.
- R8: In a read-back command, bits 3:1 select channels 0, 1 and 2. A clear bit 5 freezes each selected channel's count under the rule of R7. A clear bit 4 captures status for each selected channel that has no status pending. Unselected channels are untouched.
- R9: The status byte holds the channel output in bit 7, 0 in bit 6, the access pattern in bits 5:4, the mode in bits 3:1 and BCD in bit 0, as they stood at the read-back write.
- R10: A data read returns a pending status byte first, then any pending count snapshot bytes, and only then live count bytes.
- R11: Reading the control address returns 8'h00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe; state advances at the clock edge ending the cycle |
| host_addr | input | 2 | 0 to 2 select a channel data port, 3 the control port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle `host_rd` is high |
| cnt_load | output | 3 | Per-channel one-cycle strobe of a new initial count |
| cnt_init | output | 48 | Per-channel initial count, channel n in bits 16n+15:16n |
| cnt_mode | output | 9 | Per-channel counting mode, channel n in bits 3n+2:3n |
| cnt_bcd | output | 3 | Per-channel BCD flag |
| cnt_live | input | 48 | Per-channel live count, channel n in bits 16n+15:16n |
| cnt_out | input | 3 | Per-channel counter output level |

## Verification
Most state here hides until the host reads. A byte sequence that is out of step shows up as swapped high and low bytes on the next read or as a wrong `cnt_init` on the next completed load. A snapshot flag stuck set or cleared shows up on the first read after the freeze as a stale or live value where the other was due. The bench therefore follows every freeze, read-back and reprogramming with reads that run through the whole priority chain. It changes the live count and output levels between capture and read-out, so a snapshot taken at the wrong time or never taken differs in the very next byte. Load strobes are matched against an expected queue, so an extra or missing load is caught in the cycle it occurs or when the run ends.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = 2 * BYTE_W;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] CTL_ADDR     = 2'd3;
  localparam logic [1:0]        SEL_READBACK = 2'd3;

  // control word field positions (decoded by the channel logic)
  localparam int unsigned CW_SEL_LSB   = 6;
  localparam int unsigned CW_ACC_LSB   = 4;
  localparam int unsigned CW_MODE_LSB  = 1;
  localparam int unsigned CW_BCD_BIT   = 0;
  localparam int unsigned RB_NOCNT_BIT = 5;
  localparam int unsigned RB_NOSTS_BIT = 4;
  localparam int unsigned RB_CH_LSB    = 1;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'd0,
    ACC_LO     = 2'd1,
    ACC_HI     = 2'd2,
    ACC_WORD   = 2'd3
  } acc_e;

  // pending count snapshot: which byte(s) remain to be read
  typedef enum logic [1:0] {
    SNAP_NONE = 2'd0,
    SNAP_LO   = 2'd1,
    SNAP_HI   = 2'd2,
    SNAP_WORD = 2'd3
  } snap_e;

  typedef struct packed {
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } chan_cfg_t;

  typedef struct packed {
    logic prog;
    logic cnt_frz;
    logic sts_frz;
    logic data_wr;
    logic data_rd;
  } chan_cmd_t;

endpackage

// File: rtl/tmr_host_decode.sv
module tmr_host_decode
  import tmr_host_pkg::*;
(
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wdata,
  output chan_cmd_t [NUM_CH-1:0]       cmd,
  output chan_cfg_t                    new_cfg
);

  logic       ctl_wr;
  logic       rb_wr;
  logic [1:0] sel;
  acc_e       acc;

  always_comb begin
    ctl_wr       = wr_en && (addr == CTL_ADDR);
    sel          = wdata[CW_SEL_LSB +: 2];
    acc          = acc_e'(wdata[CW_ACC_LSB +: 2]);
    rb_wr        = ctl_wr && (sel == SEL_READBACK);
    new_cfg.acc  = acc;
    new_cfg.mode = wdata[CW_MODE_LSB +: MODE_W];
    new_cfg.bcd  = wdata[CW_BCD_BIT];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [1:0]        CH_SEL  = 2'(g);
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(g);

    assign cmd[g].prog    = ctl_wr && (sel == CH_SEL) && (acc != ACC_FREEZE);
    assign cmd[g].cnt_frz = (ctl_wr && (sel == CH_SEL) && (acc == ACC_FREEZE))
                          || (rb_wr && wdata[RB_CH_LSB + g] && !wdata[RB_NOCNT_BIT]);
    assign cmd[g].sts_frz = rb_wr && wdata[RB_CH_LSB + g] && !wdata[RB_NOSTS_BIT];
    assign cmd[g].data_wr = wr_en && (addr == CH_ADDR);
    assign cmd[g].data_rd = rd_en && !wr_en && (addr == CH_ADDR);
  end

endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
  import tmr_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cmd_t         cmd,
  input  chan_cfg_t         new_cfg,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_bcd,
  output logic              load_vld,
  output logic [CNT_W-1:0]  load_val
);

  chan_cfg_t         cfg_q,   cfg_d;
  logic              wr_hi_q, wr_hi_d;
  logic              rd_hi_q, rd_hi_d;
  logic [BYTE_W-1:0] stage_q, stage_d;
  logic              stage_en;
  snap_e             snap_q,  snap_d;
  logic [CNT_W-1:0]  cval_q,  cval_d;
  logic              cval_en;
  logic              sts_vld_q, sts_vld_d;
  logic [BYTE_W-1:0] sts_q,   sts_d;
  logic              sts_en;
  logic              ld_vld_q, ld_vld_d;
  logic [CNT_W-1:0]  ld_val_q, ld_val_d;
  logic              ld_en;
  logic [BYTE_W-1:0] sts_now;

  assign sts_now = {live_out, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};

  // next-state
  always_comb begin
    cfg_d     = cfg_q;
    wr_hi_d   = wr_hi_q;
    rd_hi_d   = rd_hi_q;
    stage_d   = stage_q;
    stage_en  = 1'b0;
    snap_d    = snap_q;
    cval_d    = cval_q;
    cval_en   = 1'b0;
    sts_vld_d = sts_vld_q;
    sts_d     = sts_q;
    sts_en    = 1'b0;
    ld_vld_d  = 1'b0;
    ld_val_d  = ld_val_q;
    ld_en     = 1'b0;

    if (cmd.prog) begin
      cfg_d     = new_cfg;
      wr_hi_d   = 1'b0;
      rd_hi_d   = 1'b0;
      snap_d    = SNAP_NONE;
      sts_vld_d = 1'b0;
    end

    if (cmd.cnt_frz && (snap_q == SNAP_NONE)) begin
      cval_d  = live_count;
      cval_en = 1'b1;
      snap_d  = snap_e'(cfg_q.acc);
    end

    if (cmd.sts_frz && !sts_vld_q) begin
      sts_vld_d = 1'b1;
      sts_d     = sts_now;
      sts_en    = 1'b1;
    end

    if (cmd.data_wr) begin
      unique case (cfg_q.acc)
        ACC_LO: begin
          ld_vld_d = 1'b1;
          ld_val_d = {{BYTE_W{1'b0}}, wdata};
          ld_en    = 1'b1;
        end
        ACC_HI: begin
          ld_vld_d = 1'b1;
          ld_val_d = {wdata, {BYTE_W{1'b0}}};
          ld_en    = 1'b1;
        end
        default: begin
          if (wr_hi_q) begin
            ld_vld_d = 1'b1;
            ld_val_d = {wdata, stage_q};
            ld_en    = 1'b1;
            wr_hi_d  = 1'b0;
          end else begin
            stage_d  = wdata;
            stage_en = 1'b1;
            wr_hi_d  = 1'b1;
          end
        end
      endcase
    end

    if (cmd.data_rd) begin
      if (sts_vld_q) begin
        sts_vld_d = 1'b0;
      end else if (snap_q != SNAP_NONE) begin
        snap_d = (snap_q == SNAP_WORD) ? SNAP_HI : SNAP_NONE;
      end else if (cfg_q.acc == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{acc: ACC_WORD, mode: '0, bcd: 1'b0};
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      stage_q   <= '0;
      snap_q    <= SNAP_NONE;
      cval_q    <= '0;
      sts_vld_q <= 1'b0;
      sts_q     <= '0;
      ld_vld_q  <= 1'b0;
      ld_val_q  <= '0;
    end else begin
      cfg_q     <= cfg_d;
      wr_hi_q   <= wr_hi_d;
      rd_hi_q   <= rd_hi_d;
      snap_q    <= snap_d;
      sts_vld_q <= sts_vld_d;
      ld_vld_q  <= ld_vld_d;
      if (stage_en) stage_q  <= stage_d;
      if (cval_en)  cval_q   <= cval_d;
      if (sts_en)   sts_q    <= sts_d;
      if (ld_en)    ld_val_q <= ld_val_d;
    end
  end

  // read byte selection: status, then snapshot, then live
  always_comb begin
    if (sts_vld_q) begin
      rd_byte = sts_q;
    end else if (snap_q != SNAP_NONE) begin
      rd_byte = (snap_q == SNAP_HI) ? cval_q[CNT_W-1:BYTE_W] : cval_q[BYTE_W-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_LO:  rd_byte = live_count[BYTE_W-1:0];
        ACC_HI:  rd_byte = live_count[CNT_W-1:BYTE_W];
        default: rd_byte = rd_hi_q ? live_count[CNT_W-1:BYTE_W] : live_count[BYTE_W-1:0];
      endcase
    end
  end

  assign cfg_mode = cfg_q.mode;
  assign cfg_bcd  = cfg_q.bcd;
  assign load_vld = ld_vld_q;
  assign load_val = ld_val_q;

endmodule

// File: rtl/tmr_host_rdmux.sv
module tmr_host_rdmux
  import tmr_host_pkg::*;
(
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  ch_byte,
  output logic [BYTE_W-1:0]              rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(i)) rdata = ch_byte[i];
      end
    end
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [BYTE_W-1:0]          host_wdata,
  output logic [BYTE_W-1:0]          host_rdata,
  output logic [NUM_CH-1:0]          cnt_load,
  output logic [NUM_CH*CNT_W-1:0]    cnt_init,
  output logic [NUM_CH*MODE_W-1:0]   cnt_mode,
  output logic [NUM_CH-1:0]          cnt_bcd,
  input  logic [NUM_CH*CNT_W-1:0]    cnt_live,
  input  logic [NUM_CH-1:0]          cnt_out
);

  logic [SYNC_STAGES-1:0]         rst_pipe_q;
  logic                           core_rst_n;
  chan_cmd_t [NUM_CH-1:0]         cmd;
  chan_cfg_t                      new_cfg;
  logic [NUM_CH-1:0][BYTE_W-1:0]  ch_byte;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign core_rst_n = rst_pipe_q[SYNC_STAGES-1];

  tmr_host_decode u_decode (
    .wr_en   (host_wr),
    .rd_en   (host_rd),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .cmd     (cmd),
    .new_cfg (new_cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    tmr_host_chan u_chan (
      .clk        (clk),
      .rst_n      (core_rst_n),
      .cmd        (cmd[g]),
      .new_cfg    (new_cfg),
      .wdata      (host_wdata),
      .live_count (cnt_live[g*CNT_W +: CNT_W]),
      .live_out   (cnt_out[g]),
      .rd_byte    (ch_byte[g]),
      .cfg_mode   (cnt_mode[g*MODE_W +: MODE_W]),
      .cfg_bcd    (cnt_bcd[g]),
      .load_vld   (cnt_load[g]),
      .load_val   (cnt_init[g*CNT_W +: CNT_W])
    );
  end

  tmr_host_rdmux u_rdmux (
    .rd_en   (host_rd),
    .addr    (host_addr),
    .ch_byte (ch_byte),
    .rdata   (host_rdata)
  );

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_host_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_wr,
  input logic                      host_rd,
  input logic [ADDR_W-1:0]         host_addr,
  input logic [BYTE_W-1:0]         host_wdata,
  input logic [BYTE_W-1:0]         host_rdata,
  input logic [NUM_CH-1:0]         cnt_load,
  input logic [NUM_CH*MODE_W-1:0]  cnt_mode,
  input logic [NUM_CH-1:0]         cnt_bcd
);

  // follows the reset release of the checked block
  logic [SYNC_STAGES-1:0] rdy_q;
  logic                   chk_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= {rdy_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign chk_rdy = rdy_q[SYNC_STAGES-1];

  // R11: control port reads as zero
  a_r11_ctl_read_zero: assert property (@(posedge clk) disable iff (!chk_rdy)
    (host_rd && (host_addr == CTL_ADDR)) |-> (host_rdata == '0));

  // R2: mode and BCD move only on a control write
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!chk_rdy)
    !(host_wr && (host_addr == CTL_ADDR)) |=> ($stable(cnt_mode) && $stable(cnt_bcd)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R4: a load strobe follows a data write to the same channel
    a_r4_load_after_write: assert property (@(posedge clk) disable iff (!chk_rdy)
      cnt_load[g] |-> $past(host_wr && (host_addr == ADDR_W'(g))));

    // R2: programming takes the mode and BCD fields
    a_r2_cfg_take: assert property (@(posedge clk) disable iff (!chk_rdy)
      (host_wr && (host_addr == CTL_ADDR) && (host_wdata[7:6] == 2'(g))
       && (host_wdata[5:4] != 2'd0))
      |=> ((cnt_mode[g*MODE_W +: MODE_W] == $past(host_wdata[3:1]))
           && (cnt_bcd[g] == $past(host_wdata[0]))));
  end

endmodule

bind tmr_host_if tmr_host_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .cnt_load   (cnt_load),
  .cnt_mode   (cnt_mode),
  .cnt_bcd    (cnt_bcd)
);

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  import tmr_host_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                      rst_n;
  logic                      host_wr;
  logic                      host_rd;
  logic [ADDR_W-1:0]         host_addr;
  logic [BYTE_W-1:0]         host_wdata;
  logic [BYTE_W-1:0]         host_rdata;
  logic [NUM_CH-1:0]         cnt_load;
  logic [NUM_CH*CNT_W-1:0]   cnt_init;
  logic [NUM_CH*MODE_W-1:0]  cnt_mode;
  logic [NUM_CH-1:0]         cnt_bcd;
  logic [NUM_CH*CNT_W-1:0]   cnt_live;
  logic [NUM_CH-1:0]         cnt_out;

  tmr_host_if uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cnt_load(cnt_load), .cnt_init(cnt_init), .cnt_mode(cnt_mode),
    .cnt_bcd(cnt_bcd), .cnt_live(cnt_live), .cnt_out(cnt_out)
  );

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  typedef struct { int ch; logic [15:0] val; string tag; } ld_item_t;

  rd_item_t rd_q[$];
  ld_item_t ld_q[$];
  int  n_chk = 0;
  int  n_err = 0;
  bit  ended = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // driver tasks
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    rd_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic exp_load(input int ch, input logic [15:0] v, input string tag);
    ld_q.push_back('{ch: ch, val: v, tag: tag});
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    cnt_live[ch*CNT_W +: CNT_W] = v;
  endtask

  // monitor: compares read bytes and load strobes against the queues
  initial begin
    rd_item_t ri;
    ld_item_t li;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (host_rd) begin
          if (rd_q.size() == 0) begin
            check("R5 read with nothing expected", 32'd1, 32'd0);
          end else begin
            ri = rd_q.pop_front();
            check(ri.tag, {24'd0, host_rdata}, {24'd0, ri.exp});
          end
        end
        for (int c = 0; c < NUM_CH; c++) begin
          if (cnt_load[c]) begin
            if (ld_q.size() == 0) begin
              check("R4 unexpected load on channel", c, 32'hFF);
            end else begin
              li = ld_q.pop_front();
              check({li.tag, " channel"}, c, li.ch);
              check({li.tag, " value"}, {16'd0, cnt_init[c*CNT_W +: CNT_W]}, {16'd0, li.val});
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    cnt_live = '0; cnt_out = '0;
    set_live(0, 16'hA1B2); set_live(1, 16'h5678); set_live(2, 16'h9ABC);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 load idle", {29'd0, cnt_load}, 32'd0);
    check("R1 mode", {23'd0, cnt_mode}, 32'd0);
    check("R1 bcd", {29'd0, cnt_bcd}, 32'd0);
    rd(2'd3, 8'h00, "R11 control read after reset");
    rd(2'd0, 8'hB2, "R1 word access low first");
    rd(2'd0, 8'hA1, "R1 word access high second");

    // R2 programming
    set_live(0, 16'h1234);
    wr(2'd3, 8'h35);
    wr(2'd3, 8'h56);
    wr(2'd3, 8'hA8);
    #1;
    check("R2 modes", {23'd0, cnt_mode}, 32'h11A);
    check("R2 bcd", {29'd0, cnt_bcd}, 32'h1);

    // R4 loads
    exp_load(1, 16'h007E, "R4 low only load");
    wr(2'd1, 8'h7E);
    exp_load(2, 16'h5C00, "R4 high only load");
    wr(2'd2, 8'h5C);
    wr(2'd0, 8'h11);
    exp_load(0, 16'h2211, "R4 word load");
    wr(2'd0, 8'h22);

    // R5 live reads
    rd(2'd1, 8'h78, "R5 low only read");
    rd(2'd1, 8'h78, "R5 low only read again");
    rd(2'd2, 8'h9A, "R5 high only read");
    wr(2'd0, 8'h33);
    rd(2'd0, 8'h34, "R5 read sequence independent low");
    rd(2'd0, 8'h12, "R5 read sequence independent high");
    exp_load(0, 16'h4433, "R5 write sequence kept");
    wr(2'd0, 8'h44);

    // R6 and R7 on a word channel
    wr(2'd3, 8'h00);
    set_live(0, 16'h4321);
    rd(2'd0, 8'h34, "R6 frozen low");
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h12, "R7 second freeze ignored");
    rd(2'd0, 8'h21, "R6 released live low");
    rd(2'd0, 8'h43, "R6 released live high");

    // R6 and R7 on a low only channel
    wr(2'd3, 8'h40);
    set_live(1, 16'h0F0E);
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h78, "R7 low only keeps first snapshot");
    rd(2'd1, 8'h0E, "R6 low only released");

    // R8 R9 R10 read-back of channels 0 and 2
    cnt_out = 3'b101;
    wr(2'd3, 8'hCA);
    cnt_out = 3'b000;
    set_live(0, 16'h6655);
    set_live(2, 16'h1357);
    rd(2'd0, 8'hB5, "R9 R10 status first ch0");
    rd(2'd0, 8'h21, "R10 count after status low");
    rd(2'd0, 8'h43, "R10 count after status high");
    rd(2'd0, 8'h55, "R10 live after snapshots low");
    rd(2'd0, 8'h66, "R10 live after snapshots high");
    rd(2'd2, 8'hA8, "R9 status ch2");
    rd(2'd2, 8'h9A, "R8 count ch2");
    rd(2'd2, 8'h13, "R10 live ch2");
    rd(2'd1, 8'h0E, "R8 unselected channel untouched");

    // R8 status only, capture once, R11 no side effect
    cnt_out = 3'b010;
    wr(2'd3, 8'hE4);
    cnt_out = 3'b000;
    wr(2'd3, 8'hE4);
    rd(2'd3, 8'h00, "R11 control read keeps pending status");
    rd(2'd1, 8'h96, "R8 R9 first status kept");
    rd(2'd1, 8'h0E, "R8 status only no count");

    // R8 count only
    set_live(1, 16'h2468);
    wr(2'd3, 8'hD4);
    set_live(1, 16'h0000);
    rd(2'd1, 8'h68, "R8 count only snapshot");
    rd(2'd1, 8'h00, "R8 count only then live");

    // R3 reprogramming clears sequences and snapshots
    set_live(0, 16'hBEEF);
    wr(2'd0, 8'h99);
    rd(2'd0, 8'hEF, "R3 setup read low");
    wr(2'd3, 8'hC2);
    wr(2'd3, 8'h30);
    rd(2'd0, 8'hEF, "R3 read restarts low with no snapshot");
    wr(2'd0, 8'h01);
    exp_load(0, 16'h0201, "R3 write restarts at first byte");
    wr(2'd0, 8'h02);
    #1;
    check("R3 R2 modes after reprogram", {23'd0, cnt_mode}, 32'h118);
    check("R3 R2 bcd after reprogram", {29'd0, cnt_bcd}, 32'h0);

    repeat (3) @(negedge clk);
    check("R4 loads still expected", rd_q.size() + ld_q.size(), 32'd0);
    finish_run();
  end

endmodule